// File: doc/BRIEF.md
# Logic and shift execution unit

This unit carries out the bitwise and shift operations of a 32-bit load/store processor pipeline. Each cycle it may receive one instruction word together with the two register operand values the register file has already read: the first-source value and the second-source value. It decodes the major opcode and, for register-format words, the function code and constant shift amount. One clock later it presents a result word, a valid flag and an illegal flag.

The unit handles bitwise AND and OR on two registers, and the same two operations against a 16-bit constant taken from the instruction. It also handles left and right shifts of the second-source value, in three kinds: logical left, logical right and arithmetic right. The shift distance comes either from the constant field of the instruction or from the low bits of the first-source register. Any word the unit does not execute is reported as illegal and produces a zero result. A parameter chooses between a staged logarithmic shifter and a shifter built from the language's shift operators.

Top module: `bitop_exec`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid`, `out_illegal` and `out_result` are cleared at that edge, whatever `in_valid` shows.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, and low after a cycle in which `in_valid` was low.
- R3: Opcode `instr[31:26]`=0 with function `instr[5:0]`=36 yields `rs_val & rt_val`, and function 37 yields `rs_val | rt_val`, bit by bit.
- R4: Opcode 12 yields `rs_val` AND the zero-extended `instr[15:0]`, and opcode 13 yields `rs_val` OR the zero-extended `instr[15:0]`. For example, 0x12345678 OR 0xFFFF gives 0x1234FFFF.
- R5: Opcode 0 with function 0 shifts `rt_val` left by `instr[10:6]` (0 to 31) positions and fills the vacated low bits with zeros.
- R6: Opcode 0 with function 2 shifts `rt_val` right by `instr[10:6]` positions and fills the vacated high bits with zeros.
- R7: Opcode 0 with function 3 shifts `rt_val` right by `instr[10:6]` positions and fills the vacated high bits with copies of `rt_val[31]`.
- R8: Functions 4, 6 and 7 act like functions 0, 2 and 3, except that the distance is `rs_val[4:0]`. `rs_val[31:5]` has no effect on the result.
- R9: Any other opcode, and opcode 0 with any other function code, raises `out_illegal` and gives `out_result` = 0 alongside `out_valid`. `out_illegal` is low in any cycle in which `out_valid` is low.
- R10: `out_result` holds its value in a cycle that follows a cycle with `in_valid` low, whatever the other inputs show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: an instruction and its operands are present |
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Value of the first-source register |
| rt_val | input | 32 | Value of the second-source register |
| out_valid | output | 1 | Result present, one cycle after the strobe |
| out_illegal | output | 1 | The word just executed is not supported |
| out_result | output | 32 | Result word |

## Verification
All outputs come from a single register stage. The result, the valid flag and the illegal flag for a strobe are therefore due at the first rising edge after the strobe edge. The idle behaviour (valid low, illegal low, result held) is due one edge after that. The bench changes inputs on falling edges and reads outputs on the next falling edge, which lies halfway between the capturing edge and the one after it. During the idle cycle it drives inverted instruction and operand values, so that any leak into the held result shows up at that falling edge.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

   localparam int INSN_W = 32;
   localparam int IMM_W  = 16;

   // major opcodes
   localparam logic [5:0] OPC_REG  = 6'd0;
   localparam logic [5:0] OPC_ANDI = 6'd12;
   localparam logic [5:0] OPC_ORI  = 6'd13;

   // register-format function codes
   localparam logic [5:0] FN_SLL  = 6'd0;
   localparam logic [5:0] FN_SRL  = 6'd2;
   localparam logic [5:0] FN_SRA  = 6'd3;
   localparam logic [5:0] FN_SLLV = 6'd4;
   localparam logic [5:0] FN_SRLV = 6'd6;
   localparam logic [5:0] FN_SRAV = 6'd7;
   localparam logic [5:0] FN_AND  = 6'd36;
   localparam logic [5:0] FN_OR   = 6'd37;

   typedef enum logic [2:0] {
      K_NONE,
      K_AND,
      K_OR,
      K_SLL,
      K_SRL,
      K_SRA
   } kind_e;

   typedef struct packed {
      logic  legal;
      kind_e kind;
      logic  use_imm;
      logic  var_amt;
   } dec_t;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
   import bitop_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output dec_t       dec
);

   always_comb begin
      dec.legal   = 1'b0;
      dec.kind    = K_NONE;
      dec.use_imm = 1'b0;
      dec.var_amt = 1'b0;
      case (opcode)
         OPC_REG: begin
            case (funct)
               FN_AND:  begin dec.legal = 1'b1; dec.kind = K_AND; end
               FN_OR:   begin dec.legal = 1'b1; dec.kind = K_OR;  end
               FN_SLL:  begin dec.legal = 1'b1; dec.kind = K_SLL; end
               FN_SRL:  begin dec.legal = 1'b1; dec.kind = K_SRL; end
               FN_SRA:  begin dec.legal = 1'b1; dec.kind = K_SRA; end
               FN_SLLV: begin dec.legal = 1'b1; dec.kind = K_SLL; dec.var_amt = 1'b1; end
               FN_SRLV: begin dec.legal = 1'b1; dec.kind = K_SRL; dec.var_amt = 1'b1; end
               FN_SRAV: begin dec.legal = 1'b1; dec.kind = K_SRA; dec.var_amt = 1'b1; end
               default: ;
            endcase
         end
         OPC_ANDI: begin dec.legal = 1'b1; dec.kind = K_AND; dec.use_imm = 1'b1; end
         OPC_ORI:  begin dec.legal = 1'b1; dec.kind = K_OR;  dec.use_imm = 1'b1; end
         default: ;
      endcase
   end

endmodule

// File: rtl/bitop_logic.sv
module bitop_logic #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              is_or,
   output logic [DATA_W-1:0] y
);

   // one independent cell per bit position
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign y[i] = is_or ? (a[i] | b[i]) : (a[i] & b[i]);
   end

endmodule

// File: rtl/bitop_shift.sv
module bitop_shift #(
   parameter int DATA_W     = 32,
   parameter int SHIFT_IMPL = 0,
   localparam int AMT_W     = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] data,
   input  logic [AMT_W-1:0]  amt,
   input  logic              go_right,
   input  logic              arith,
   output logic [DATA_W-1:0] y
);

   if (SHIFT_IMPL == 0) begin : g_staged
      logic              fill;
      logic [DATA_W-1:0] st [AMT_W+1];

      assign fill  = arith & data[DATA_W-1];
      assign st[0] = data;

      for (genvar k = 0; k < AMT_W; k++) begin : g_stage
         localparam int S = 1 << k;
         logic [DATA_W-1:0] moved;
         assign moved = go_right ? {{S{fill}}, st[k][DATA_W-1:S]}
                                 : {st[k][DATA_W-1-S:0], {S{1'b0}}};
         assign st[k+1] = amt[k] ? moved : st[k];
      end

      assign y = st[AMT_W];
   end else begin : g_operator
      always_comb begin
         if (!go_right)
            y = data << amt;
         else if (arith)
            y = DATA_W'($signed(data) >>> amt);
         else
            y = data >> amt;
      end
   end

endmodule

// File: rtl/bitop_exec.sv
module bitop_exec
   import bitop_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int SHIFT_IMPL = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [INSN_W-1:0] instr,
   input  logic [DATA_W-1:0] rs_val,
   input  logic [DATA_W-1:0] rt_val,
   output logic              out_valid,
   output logic              out_illegal,
   output logic [DATA_W-1:0] out_result
);

   localparam int AMT_W = $clog2(DATA_W);

   if (DATA_W < IMM_W || DATA_W > INSN_W || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("bitop_exec: DATA_W must be a power of two from 16 to 32");
   end
   if (SHIFT_IMPL < 0 || SHIFT_IMPL > 1) begin : g_bad_impl
      $error("bitop_exec: SHIFT_IMPL must be 0 (staged) or 1 (operator)");
   end

   dec_t              dec;
   logic [DATA_W-1:0] imm_ext;
   logic [DATA_W-1:0] opnd_b;
   logic [AMT_W-1:0]  amt;
   logic [DATA_W-1:0] logic_y;
   logic [DATA_W-1:0] shift_y;
   logic              is_logic;
   logic              go_right;
   logic [DATA_W-1:0] next_result;
   wire               unused_fields = ^instr[25:16];

   bitop_decode u_dec (
      .opcode (instr[31:26]),
      .funct  (instr[5:0]),
      .dec    (dec)
   );

   assign imm_ext  = DATA_W'(instr[IMM_W-1:0]);
   assign opnd_b   = dec.use_imm ? imm_ext : rt_val;
   assign amt      = dec.var_amt ? rs_val[AMT_W-1:0] : instr[6 +: AMT_W];
   assign is_logic = (dec.kind == K_AND) || (dec.kind == K_OR);
   assign go_right = (dec.kind == K_SRL) || (dec.kind == K_SRA);

   bitop_logic #(.DATA_W(DATA_W)) u_logic (
      .a     (rs_val),
      .b     (opnd_b),
      .is_or (dec.kind == K_OR),
      .y     (logic_y)
   );

   bitop_shift #(.DATA_W(DATA_W), .SHIFT_IMPL(SHIFT_IMPL)) u_shift (
      .data     (rt_val),
      .amt      (amt),
      .go_right (go_right),
      .arith    (dec.kind == K_SRA),
      .y        (shift_y)
   );

   always_comb begin
      if (!dec.legal)
         next_result = '0;
      else if (is_logic)
         next_result = logic_y;
      else
         next_result = shift_y;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid   <= 1'b0;
         out_illegal <= 1'b0;
         out_result  <= '0;
      end else begin
         out_valid   <= in_valid;
         out_illegal <= in_valid & ~dec.legal;
         if (in_valid)
            out_result <= next_result;
      end
   end

endmodule

// File: rtl/bitop_exec_chk.sv
module bitop_exec_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [31:0]       instr,
   input logic [DATA_W-1:0] rs_val,
   input logic [DATA_W-1:0] rt_val,
   input logic              out_valid,
   input logic              out_illegal,
   input logic [DATA_W-1:0] out_result
);

   wire unused_chk = ^instr[25:6];

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (!out_valid && !out_illegal && out_result == '0));

   p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   p_valid_quiet_r2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   p_and_result_r3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && instr[31:26] == 6'd0 && instr[5:0] == 6'd36)
      |=> out_result == $past(rs_val & rt_val));

   p_sra_sign_r7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && instr[31:26] == 6'd0 && instr[5:0] == 6'd3 && rt_val[DATA_W-1])
      |=> out_result[DATA_W-1]);

   p_illegal_zero_r9: assert property (@(posedge clk) disable iff (rst)
      out_illegal |-> (out_valid && out_result == '0));

   p_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_result));

endmodule

bind bitop_exec bitop_exec_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .in_valid    (in_valid),
   .instr       (instr),
   .rs_val      (rs_val),
   .rt_val      (rt_val),
   .out_valid   (out_valid),
   .out_illegal (out_illegal),
   .out_result  (out_result)
);

// File: tb/bitop_exec_tb.sv
module bitop_exec_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] rs_v = '0;
   logic [31:0] rt_v = '0;
   logic        out_valid;
   logic        out_illegal;
   logic [31:0] out_result;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   bitop_exec u_dut (
      .clk         (clk),
      .rst         (rst),
      .in_valid    (in_valid),
      .instr       (instr),
      .rs_val      (rs_v),
      .rt_val      (rt_v),
      .out_valid   (out_valid),
      .out_illegal (out_illegal),
      .out_result  (out_result)
   );

   function automatic logic [31:0] rword(input logic [5:0] fn, input logic [4:0] sh);
      return {6'd0, 5'd9, 5'd10, 5'd8, sh, fn};
   endfunction

   function automatic logic [31:0] iword(input logic [5:0] op, input logic [15:0] imm);
      return {op, 5'd3, 5'd4, imm};
   endfunction

   // arithmetic reference shifts
   function automatic logic [31:0] mul_pow(input logic [31:0] x, input int n);
      longint unsigned p = 64'd1 << n;
      longint unsigned r = 64'(x) * p;
      return r[31:0];
   endfunction

   function automatic logic [31:0] div_pow(input logic [31:0] x, input int n);
      longint unsigned p = 64'd1 << n;
      return 32'(64'(x) / p);
   endfunction

   function automatic logic [31:0] sdiv_pow(input logic [31:0] x, input int n);
      if (x[31]) return ~div_pow(~x, n);
      return div_pow(x, n);
   endfunction

   // returns {illegal, result}
   function automatic logic [32:0] model(input logic [31:0] ins, a, b);
      logic [5:0] op = ins[31:26];
      logic [5:0] fn = ins[5:0];
      int sh = int'(ins[10:6]);
      int va = int'(a % 32);
      logic [31:0] imm = {16'h0000, ins[15:0]};
      if (op == 6'd12) return {1'b0, a & imm};
      if (op == 6'd13) return {1'b0, a | imm};
      if (op != 6'd0) return {1'b1, 32'h0};
      case (fn)
         6'd36:   return {1'b0, a & b};
         6'd37:   return {1'b0, a | b};
         6'd0:    return {1'b0, mul_pow(b, sh)};
         6'd2:    return {1'b0, div_pow(b, sh)};
         6'd3:    return {1'b0, sdiv_pow(b, sh)};
         6'd4:    return {1'b0, mul_pow(b, va)};
         6'd6:    return {1'b0, div_pow(b, va)};
         6'd7:    return {1'b0, sdiv_pow(b, va)};
         default: return {1'b1, 32'h0};
      endcase
   endfunction

   function automatic string reqtag(input logic [31:0] ins);
      logic [5:0] op = ins[31:26];
      logic [5:0] fn = ins[5:0];
      if (op == 6'd12 || op == 6'd13) return "R4";
      if (op != 6'd0) return "R9";
      case (fn)
         6'd36, 6'd37:        return "R3";
         6'd0:                return "R5";
         6'd2:                return "R6";
         6'd3:                return "R7";
         6'd4, 6'd6, 6'd7:    return "R8";
         default:             return "R9";
      endcase
   endfunction

   task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
      nchk++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h (instr %h)", what, got, exp, instr);
      end
   endtask

   task automatic apply(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
      logic [32:0] e = model(ins, a, b);
      string t = reqtag(ins);
      @(negedge clk);
      instr = ins; rs_v = a; rt_v = b; in_valid = 1'b1;
      @(negedge clk);
      chk({"R2 valid after strobe (", t, ")"}, 32'(out_valid), 32'd1);
      chk({t, " result"}, out_result, e[31:0]);
      chk({"R9 illegal flag (", t, ")"}, 32'(out_illegal), 32'(e[32]));
      in_valid = 1'b0; instr = ~ins; rs_v = ~a; rt_v = b ^ 32'hA5A5_0F0F;
      @(negedge clk);
      chk("R2 valid low when idle", 32'(out_valid), 32'd0);
      chk("R9 illegal low when idle", 32'(out_illegal), 32'd0);
      chk("R10 result held when idle", out_result, e[31:0]);
   endtask

   logic [31:0] pats [4] = '{32'h1234_5678, 32'h9234_5678, 32'hFFFF_FFFF, 32'h8000_0001};
   logic [15:0] imms [4] = '{16'hFFFF, 16'h0FFF, 16'h0000, 16'h8001};
   logic [5:0]  cfn  [3] = '{6'd0, 6'd2, 6'd3};
   logic [5:0]  vfn  [3] = '{6'd4, 6'd6, 6'd7};

   initial begin
      // R1: reset holds outputs clear even with a strobe present
      instr = rword(6'd37, 5'd0); rs_v = 32'hFFFF_FFFF; rt_v = 32'h1; in_valid = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", 32'(out_valid), 32'd0);
      chk("R1 illegal in reset", 32'(out_illegal), 32'd0);
      chk("R1 result in reset", out_result, 32'd0);
      in_valid = 1'b0; rst = 1'b0;
      @(negedge clk);
      chk("R2 no valid without strobe", 32'(out_valid), 32'd0);

      // R4: worked examples
      apply(iword(6'd13, 16'hFFFF), 32'h1234_5678, 32'h0);
      chk("R4 ori example", out_result, 32'h1234_FFFF);
      apply(iword(6'd12, 16'h0FFF), 32'hB6A4_3D9A, 32'h0);
      chk("R4 andi low 12 bits", out_result, 32'h0000_0D9A);

      // R3 and R4: logical forms over operand and immediate patterns
      for (int i = 0; i < 4; i++) begin
         for (int j = 0; j < 4; j++) begin
            apply(rword(6'd36, 5'd0), pats[i], pats[j] ^ 32'h0F0F_3C3C);
            apply(rword(6'd37, 5'd0), pats[i], pats[j] ^ 32'h0F0F_3C3C);
            apply(iword(6'd12, imms[j]), pats[i], pats[j]);
            apply(iword(6'd13, imms[j]), pats[i], pats[j]);
         end
      end

      // R5, R6, R7: constant-distance shifts, every distance
      for (int f = 0; f < 3; f++) begin
         for (int s = 0; s < 32; s++) begin
            for (int p = 0; p < 4; p++) begin
               apply(rword(cfn[f], 5'(s)), 32'hDEAD_BEEF, pats[p]);
            end
         end
      end

      // R8: register-distance shifts with noisy upper distance bits
      for (int f = 0; f < 3; f++) begin
         for (int s = 0; s < 32; s++) begin
            apply(rword(vfn[f], 5'd17), (32'h5A5A_5A5A & ~32'h1F) | 32'(s), pats[1]);
            apply(rword(vfn[f], 5'd3), 32'hFFFF_FFE0 | 32'(s), pats[0]);
         end
      end

      // R9: every function code under opcode 0, every other opcode
      for (int fn = 0; fn < 64; fn++) begin
         apply(rword(6'(fn), 5'd4), 32'hC3C3_0001, 32'h8765_4321);
      end
      for (int op = 1; op < 64; op++) begin
         apply(iword(6'(op), 16'h1234), 32'hFFFF_0000, 32'h0000_FFFF);
      end

      // R1: reset in the middle of traffic wins over a strobe
      apply(rword(6'd37, 5'd0), 32'h0000_00F0, 32'h0000_000F);
      @(negedge clk);
      instr = rword(6'd37, 5'd0); rs_v = 32'h1; rt_v = 32'h2; in_valid = 1'b1; rst = 1'b1;
      @(negedge clk);
      chk("R1 valid cleared", 32'(out_valid), 32'd0);
      chk("R1 illegal cleared", 32'(out_illegal), 32'd0);
      chk("R1 result cleared", out_result, 32'd0);
      rst = 1'b0; in_valid = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

endmodule